// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer arithmetic and logic unit of a small RISC core. In one combinational pass it adds, subtracts or applies a bitwise function to two operands. A 4-bit opcode picks the function and a set-flags input decides whether the negative, zero, carry and overflow flags take new values. The carry-out of the operand shifter comes in on its own input, so logical operations can pass it into the carry flag. The operand shifter itself sits outside this block.

The flags live in a four-bit register inside the block. That register feeds the carry-in of the carried forms and is also visible at the ports. A status-word write opcode loads all four flags straight from the top nibble of operand A. Carry follows the "no borrow" convention on subtraction. The reverse forms compute B minus A through the same adder and the same flag rules.

The flags are packed as {N, Z, C, V} in bits 3..0 of `flags` and `nextFlags`. Opcode encoding: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 RSB, 5 RSC, 6 AND, 7 XOR, 8 OR, 9 BIC, 10 MVN, 12 status write. Codes 11, 13, 14 and 15 are reserved.

Top module: `flag_alu`

## Requirements
- R1: ADD (0) gives a+b and ADC (1) gives a+b+C, where C is the registered carry flag; with set-flags high, C becomes the unsigned carry out of the top bit.
- R2: For ADD and ADC with set-flags high, V is set exactly when the signed sum a+b(+C) does not fit in the signed result width.
- R3: SUB (2) gives a-b with C set when a >= b unsigned; SBC (3) gives a-b-1 when C is clear (new C = a > b unsigned) and a-b when C is set (new C = a >= b unsigned).
- R4: For SUB and SBC with set-flags high, V is set exactly when the signed difference a-b-borrow does not fit in the signed result width.
- R5: RSB (4) and RSC (5) behave as SUB and SBC with a and b exchanged, in both result and flags.
- R6: AND (6), XOR (7), OR (8), BIC (9, a AND NOT b) and MVN (10, NOT b) produce their bitwise result; with set-flags high, C takes the shift-carry input and V keeps its value.
- R7: For every opcode 0 to 10 with set-flags high, N becomes result bit 31 and Z is set exactly when the result is zero.
- R8: With set-flags low, every opcode except the status write leaves all four flags unchanged, and the result is still produced.
- R9: Status write (12) loads N, Z, C, V from operand A bits 31, 30, 29, 28 whether set-flags is high or low, and drives operand A on the result.
- R10: Reserved opcodes (11, 13, 14, 15) drive a zero result and leave the flags unchanged.
- R11: A synchronous active-high reset clears all four flags and takes priority over any flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Operation select |
| setFlags | input | 1 | Allows arithmetic and logical opcodes to update the flags |
| opA | input | WIDTH | First operand, also the status word source |
| opB | input | WIDTH | Second operand, normally from the shifter |
| shiftCarry | input | 1 | Shifter carry-out, loaded into C by logical opcodes |
| result | output | WIDTH | Combinational result |
| nextFlags | output | 4 | Flag value to be loaded at the next edge, {N,Z,C,V} |
| flags | output | 4 | Registered flags, {N,Z,C,V} |

## Verification
The sweep crosses every opcode with operands at the sign and carry boundaries: 0, 1, the largest positive value, the most negative value, all ones, and neighbours of these. It does so with both states of the incoming carry and of set-flags. This exposes an ADC or SBC that uses the wrong carry sense; such a design would be off by one in the result or flip C when a equals b. It also exposes a reverse subtract that swaps only the result and not the flag inputs, and a V computed from the wrong operand's sign. Logical opcodes are checked for V being kept, since a design that cleared V would lose a pending overflow. The status write and reset are checked with set-flags low and high, and the reserved codes are checked for a zero result and unchanged flags.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OP_W = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 4'd0,
    OP_ADC    = 4'd1,
    OP_SUB    = 4'd2,
    OP_SBC    = 4'd3,
    OP_RSB    = 4'd4,
    OP_RSC    = 4'd5,
    OP_AND    = 4'd6,
    OP_XOR    = 4'd7,
    OP_OR     = 4'd8,
    OP_BIC    = 4'd9,
    OP_MVN    = 4'd10,
    OP_STATUS = 4'd12
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  typedef enum logic [2:0] {
    LG_AND = 3'd0,
    LG_XOR = 3'd1,
    LG_OR  = 3'd2,
    LG_BIC = 3'd3,
    LG_MVN = 3'd4
  } logicFn_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic     useAdder;
    logic     swapOps;
    logic     invertB;
    cinSel_e  cinSel;
    logic     isLogic;
    logicFn_e logicFn;
    logic     isStatusWr;
  } aluCtrl_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{useAdder: 1'b0, swapOps: 1'b0, invertB: 1'b0, cinSel: CIN_ZERO,
             isLogic: 1'b0, logicFn: LG_AND, isStatusWr: 1'b0};
    case (opcode)
      OP_ADD: begin
        ctrl.useAdder = 1'b1;
      end
      OP_ADC: begin
        ctrl.useAdder = 1'b1;
        ctrl.cinSel   = CIN_FLAG;
      end
      OP_SUB: begin
        ctrl.useAdder = 1'b1;
        ctrl.invertB  = 1'b1;
        ctrl.cinSel   = CIN_ONE;
      end
      OP_SBC: begin
        ctrl.useAdder = 1'b1;
        ctrl.invertB  = 1'b1;
        ctrl.cinSel   = CIN_FLAG;
      end
      OP_RSB: begin
        ctrl.useAdder = 1'b1;
        ctrl.swapOps  = 1'b1;
        ctrl.invertB  = 1'b1;
        ctrl.cinSel   = CIN_ONE;
      end
      OP_RSC: begin
        ctrl.useAdder = 1'b1;
        ctrl.swapOps  = 1'b1;
        ctrl.invertB  = 1'b1;
        ctrl.cinSel   = CIN_FLAG;
      end
      OP_AND: begin
        ctrl.isLogic = 1'b1;
        ctrl.logicFn = LG_AND;
      end
      OP_XOR: begin
        ctrl.isLogic = 1'b1;
        ctrl.logicFn = LG_XOR;
      end
      OP_OR: begin
        ctrl.isLogic = 1'b1;
        ctrl.logicFn = LG_OR;
      end
      OP_BIC: begin
        ctrl.isLogic = 1'b1;
        ctrl.logicFn = LG_BIC;
      end
      OP_MVN: begin
        ctrl.isLogic = 1'b1;
        ctrl.logicFn = LG_MVN;
      end
      OP_STATUS: begin
        ctrl.isStatusWr = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  aluCtrl_t          ctrl,
  input  logic              setFlags,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              shiftCarry,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] nextFlags,
  output logic [FLAG_W-1:0] flags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] srcX;
  logic [WIDTH-1:0] srcY;
  logic [WIDTH-1:0] addendY;
  logic             carryIn;
  logic [WIDTH:0]   sumFull;
  logic [WIDTH-1:0] logicRes;
  logic             arithC;
  logic             arithV;
  logic             resN;
  logic             resZ;

  // Reverse forms only exchange the adder inputs
  assign srcX    = ctrl.swapOps ? opB : opA;
  assign srcY    = ctrl.swapOps ? opA : opB;
  assign addendY = ctrl.invertB ? ~srcY : srcY;

  always_comb begin
    case (ctrl.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flags[1];
      default:  carryIn = 1'b0;
    endcase
  end

  assign sumFull = {1'b0, srcX} + {1'b0, addendY} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    case (ctrl.logicFn)
      LG_XOR:  logicRes = opA ^ opB;
      LG_OR:   logicRes = opA | opB;
      LG_BIC:  logicRes = opA & ~opB;
      LG_MVN:  logicRes = ~opB;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    if (ctrl.isStatusWr)    result = opA;
    else if (ctrl.useAdder) result = sumFull[WIDTH-1:0];
    else if (ctrl.isLogic)  result = logicRes;
    else                    result = '0;
  end

  assign arithC = sumFull[WIDTH];
  assign arithV = (srcX[MSB] == addendY[MSB]) && (sumFull[MSB] != srcX[MSB]);
  assign resN   = result[MSB];
  assign resZ   = (result == '0);

  always_comb begin
    nextFlags = flags;
    if (ctrl.isStatusWr)
      nextFlags = opA[MSB -: FLAG_W];
    else if (setFlags && ctrl.useAdder)
      nextFlags = {resN, resZ, arithC, arithV};
    else if (setFlags && ctrl.isLogic)
      nextFlags = {resN, resZ, shiftCarry, flags[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nextFlags;
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        opcode,
  input  logic              setFlags,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              shiftCarry,
  output logic [WIDTH-1:0]  result,
  output logic [3:0]        nextFlags,
  output logic [3:0]        flags
);

  aluCtrl_t ctrlBus;

  flag_alu_ctrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrlBus)
  );

  flag_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrlBus),
    .setFlags   (setFlags),
    .opA        (opA),
    .opB        (opB),
    .shiftCarry (shiftCarry),
    .result     (result),
    .nextFlags  (nextFlags),
    .flags      (flags)
  );

endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       opcode,
  input logic             setFlags,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags
);

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!setFlags && opcode != OP_STATUS) |=> (flags == $past(flags)));

  assert_status_load_R9: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_STATUS) |=> (flags == $past(opA[WIDTH-1 -: 4])));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd11 || opcode > OP_STATUS) |-> (result == '0));

  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd11 || opcode > OP_STATUS) |=> (flags == $past(flags)));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (setFlags && opcode <= OP_MVN) |=> (flags[2] == ($past(result) == '0)));

  assert_neg_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (setFlags && opcode <= OP_MVN) |=> (flags[3] == $past(result[WIDTH-1])));

  assert_logic_v_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (setFlags && opcode >= OP_AND && opcode <= OP_MVN) |=> (flags[0] == $past(flags[0])));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (flags == 4'b0000));

endmodule

bind flag_alu flag_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opcode   (opcode),
  .setFlags (setFlags),
  .opA      (opA),
  .result   (result),
  .flags    (flags)
);

// File: tb/flag_alu_test.sv
module flag_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    opcode = 4'd0;
  logic          setFlags = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          shiftCarry = 1'b0;
  logic [W-1:0]  result;
  logic [3:0]    nextFlags;
  logic [3:0]    flags;

  int vecCount = 0;
  int missCount = 0;
  logic [3:0] modelFlags = 4'b0;
  logic [W-1:0] cornerVals [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .opcode(opcode), .setFlags(setFlags),
    .opA(opA), .opB(opB), .shiftCarry(shiftCarry),
    .result(result), .nextFlags(nextFlags), .flags(flags)
  );

  function automatic string reqOf(input logic [3:0] op, input logic sf);
    if (op == 4'd12) return "R9";
    if (op == 4'd11 || op > 4'd12) return "R10";
    if (!sf) return "R8";
    if (op <= 4'd1) return "R1/R2/R7";
    if (op <= 4'd3) return "R3/R4/R7";
    if (op <= 4'd5) return "R5/R7";
    return "R6/R7";
  endfunction

  // Independent reference: returns {result, N, Z, C, V}
  function automatic logic [W+3:0] refModel(input logic [3:0] op, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [3:0] fin, input logic sf, input logic shc);
    logic [W-1:0] r;
    logic [3:0] f;
    logic [W-1:0] x, y;
    logic cIn;
    longint sx, sy, exact;
    logic [63:0] wide;
    f = fin;
    r = '0;
    cIn = fin[1];
    x = a; y = b;
    if (op == 4'd4 || op == 4'd5) begin x = b; y = a; end
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (op)
      4'd0, 4'd1: begin
        wide = {32'b0, x} + {32'b0, y} + ((op == 4'd1) ? 64'(cIn) : 64'd0);
        r = wide[W-1:0];
        exact = sx + sy + ((op == 4'd1) ? longint'(cIn) : 0);
        if (sf) f = {r[W-1], r == 0, wide[W], (exact > 64'sd2147483647) || (exact < -64'sd2147483648)};
      end
      4'd2, 4'd4, 4'd3, 4'd5: begin
        logic borrow;
        logic cOut;
        borrow = (op == 4'd3 || op == 4'd5) ? !cIn : 1'b0;
        r = x - y - W'(borrow);
        cOut = borrow ? (x > y) : (x >= y);
        exact = sx - sy - longint'(borrow);
        if (sf) f = {r[W-1], r == 0, cOut, (exact > 64'sd2147483647) || (exact < -64'sd2147483648)};
      end
      4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
        case (op)
          4'd6: r = a & b;
          4'd7: r = a ^ b;
          4'd8: r = a | b;
          4'd9: r = a & ~b;
          default: r = ~b;
        endcase
        if (sf) f = {r[W-1], r == 0, shc, fin[0]};
      end
      4'd12: begin
        r = a;
        f = a[W-1:W-4];
      end
      default: r = '0;
    endcase
    return {r, f};
  endfunction

  task automatic checkVal(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one operation on a falling edge, check result, then flags after the rising edge
  task automatic applyOp(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic sf, input logic shc);
    logic [W+3:0] expv;
    @(negedge clk);
    opcode = op; opA = a; opB = b; setFlags = sf; shiftCarry = shc;
    expv = refModel(op, a, b, modelFlags, sf, shc);
    #1;
    checkVal(reqOf(op, sf), "result", result, expv[W+3:4]);
    @(posedge clk);
    #1;
    modelFlags = expv[3:0];
    checkVal(reqOf(op, sf), "flags", W'(flags), W'(modelFlags));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    missCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    cornerVals[0] = 32'h0000_0000;
    cornerVals[1] = 32'h0000_0001;
    cornerVals[2] = 32'h7FFF_FFFF;
    cornerVals[3] = 32'h8000_0000;
    cornerVals[4] = 32'hFFFF_FFFF;
    cornerVals[5] = 32'h8000_0001;
    cornerVals[6] = 32'hFFFF_FFFE;
    cornerVals[7] = 32'h1234_5678;

    // R11: reset state
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    checkVal("R11", "reset flags", W'(flags), W'(4'b0000));
    // R11: reset wins over a status write in the same cycle
    @(negedge clk);
    opcode = 4'd12; opA = 32'hF000_0000; setFlags = 1'b1;
    @(posedge clk);
    #1;
    checkVal("R11", "reset priority", W'(flags), W'(4'b0000));
    @(negedge clk);
    rst = 1'b0;
    opcode = 4'd11;
    modelFlags = 4'b0;

    // Near-exhaustive sweep across opcodes, corner operands, flag-in and set-flags
    for (int op = 0; op < 16; op++) begin
      for (int sf = 0; sf < 2; sf++) begin
        for (int cst = 0; cst < 2; cst++) begin
          for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
              logic [3:0] preset;
              preset = {i[0], j[0], cst[0], i[1] ^ j[1]};
              // R9: preload via status write, set-flags alternating
              applyOp(4'd12, {preset, 28'h0ABCDEF}, 32'h0, j[2], 1'b0);
              applyOp(op[3:0], cornerVals[i], cornerVals[j], sf[0], i[2] ^ j[0]);
            end
          end
        end
      end
    end

    // Random vectors
    for (int k = 0; k < 3000; k++) begin
      applyOp(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom), 1'($urandom));
    end

    // R11: mid-run reset clears flags set earlier
    applyOp(4'd12, 32'hF000_0000, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    opcode = 4'd0; setFlags = 1'b1; opA = 32'hFFFF_FFFF; opB = 32'h1;
    @(posedge clk);
    #1;
    checkVal("R11", "mid-run reset", W'(flags), W'(4'b0000));
    @(negedge clk);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule